// File: doc/BRIEF.md
# NAND Command and Data Phase Write Decoder

This block sits on the slave side of a memory-mapped write channel and turns each accepted write into a short burst of NAND bus cycles. The write offset carries the control fields, not a register file. One offset bit selects a command phase and another selects a data phase. The offset also carries the opcode, the number of address cycles and the end-of-transfer flags. The 32-bit payload carries either address bytes or page data.

In a command phase the block drives one command-latch cycle with the opcode, followed by up to four address-latch cycles taken from the payload. If more address cycles are needed, it waits for a second command write that supplies the rest. In a data phase the payload word is sent as four byte cycles. The final word of a transfer can raise an ECC-last pulse. It can also append a second command opcode, so a page program needs no separate command write. The write channel is stalled while the cycles of the previous write are still going out.

Top module: `nand_phase_decoder`

## Requirements
- R1: A write is decoded by two offset bits: bit 21 alone selects the command phase and bit 20 alone selects the data phase. A write with both bits set or neither set is accepted, emits no NAND cycle and leaves `wr_ready` high.
- R2: A command-phase write that is not continuing an address sequence first emits one cycle with `nand_cle` high and `nand_io` equal to offset bits [7:0].
- R3: Offset bits [10:8] of a command-phase write give the number of address cycles N (0 to 7). The first min(N,4) of them follow the opcode with `nand_ale` high, taking payload bytes from the least significant byte upward.
- R4: When N exceeds 4, the block waits after the fourth address cycle. The next command-phase write supplies the remaining N-4 address bytes, least significant first, and emits no opcode. A data-phase write received while the block waits emits nothing.
- R5: A data-phase write emits four byte cycles with `nand_cle` and `nand_ale` low, least significant payload byte first.
- R6: When offset bit 12 of a data-phase write is set, `ecc_last` is high for exactly one clock: the clock that follows the fourth data byte. Otherwise `ecc_last` stays low.
- R7: When offset bit 13 of a data-phase write is set, one command cycle carrying offset bits [7:0] follows the fourth data byte in the very next clock.
- R8: The first NAND cycle of a write appears in the clock that follows its acceptance. The remaining cycles follow with no gaps. `wr_ready` is low for exactly (cycles emitted - 1) clocks, so back-to-back writes stream without a gap.
- R9: After reset, `wr_ready` is high, all NAND outputs and `ecc_last` are low, and no address continuation is pending.
- R10: `nand_cle` and `nand_ale` are never high together, and neither is high outside a `nand_we` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_addr | input | 24 | Write offset carrying phase and control fields |
| wr_data | input | 32 | Write payload: address bytes or a data word |
| nand_cle | output | 1 | Command latch enable of the current cycle |
| nand_ale | output | 1 | Address latch enable of the current cycle |
| nand_we | output | 1 | One-clock write strobe marking a NAND cycle |
| nand_io | output | 8 | Byte driven in the current cycle |
| ecc_last | output | 1 | One-clock pulse after the last byte of a flagged word |

## Verification
If a write is accepted at clock edge A, its k-th NAND cycle is due in the clock after edge A+k. The ECC-last pulse of a flagged word is due after edge A+4, in the same clock as any trailing command. The bench records every strobe cycle and every ECC pulse with the edge count at which it appears, sampling on the falling clock edge. It compares both the byte stream and those edge numbers against the acceptance edge of each write. It also counts the clocks in which `wr_ready` stays low after acceptance. For back-to-back writes, it checks that the second acceptance lands exactly four edges after the first.

// File: rtl/nand_dec_pkg.sv
package nand_dec_pkg;

  typedef struct packed {
    logic       cle;
    logic       ale;
    logic       ecc;
    logic [7:0] io;
  } nand_slot_t;

  typedef enum logic [1:0] {
    KIND_NONE      = 2'd0,
    KIND_CMD_FIRST = 2'd1,
    KIND_CMD_REST  = 2'd2,
    KIND_DATA      = 2'd3
  } wr_kind_e;

  localparam nand_slot_t IDLE_SLOT = '0;

  // number of address bytes that fit in one payload word
  function automatic int fit_lanes(int wanted, int lanes);
    return (wanted < lanes) ? wanted : lanes;
  endfunction

  // byte cycles issued by one write
  function automatic int data_cycles(int lanes, logic trailing_cmd);
    return lanes + (trailing_cmd ? 1 : 0);
  endfunction

endpackage

// File: rtl/nand_offset_decode.sv
module nand_offset_decode
  import nand_dec_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int CMD_BIT   = 21,
  parameter int DATA_BIT  = 20,
  parameter int OPC_LSB   = 0,
  parameter int NADDR_LSB = 8,
  parameter int NADDR_W   = 3,
  parameter int ECC_BIT   = 12,
  parameter int C2V_BIT   = 13
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               waiting,
  output wr_kind_e           kind,
  output logic [7:0]         opcode,
  output logic [NADDR_W-1:0] naddr,
  output logic               ecc_flag,
  output logic               cmd2_valid
);

  logic sel_cmd;
  logic sel_data;

  assign sel_cmd    = addr[CMD_BIT];
  assign sel_data   = addr[DATA_BIT];
  assign opcode     = addr[OPC_LSB +: 8];
  assign naddr      = addr[NADDR_LSB +: NADDR_W];
  assign ecc_flag   = addr[ECC_BIT];
  assign cmd2_valid = addr[C2V_BIT];

  always_comb begin
    kind = KIND_NONE;
    if (sel_cmd && !sel_data) begin
      kind = waiting ? KIND_CMD_REST : KIND_CMD_FIRST;
    end else if (sel_data && !sel_cmd) begin
      kind = waiting ? KIND_NONE : KIND_DATA;
    end
  end

endmodule

// File: rtl/nand_slot_builder.sv
module nand_slot_builder
  import nand_dec_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NADDR_W = 3,
  localparam int LANES  = DATA_W / 8,
  localparam int SLOTS  = LANES + 1,
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  wr_kind_e           kind,
  input  logic [7:0]         opcode,
  input  logic [NADDR_W-1:0] naddr,
  input  logic [NADDR_W-1:0] rem_in,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               ecc_flag,
  input  logic               cmd2_valid,
  output nand_slot_t         slots [SLOTS],
  output logic [CNT_W-1:0]   count,
  output logic [NADDR_W-1:0] rem_out
);

  int take;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) slots[i] = IDLE_SLOT;
    count   = '0;
    rem_out = rem_in;
    take    = 0;
    unique case (kind)
      KIND_CMD_FIRST: begin
        take     = fit_lanes(int'(naddr), LANES);
        slots[0] = '{cle: 1'b1, ale: 1'b0, ecc: 1'b0, io: opcode};
        for (int i = 0; i < LANES; i++) begin
          if (i < take) slots[i+1] = '{cle: 1'b0, ale: 1'b1, ecc: 1'b0, io: wdata[8*i +: 8]};
        end
        count   = CNT_W'(1 + take);
        rem_out = NADDR_W'(int'(naddr) - take);
      end
      KIND_CMD_REST: begin
        take = fit_lanes(int'(rem_in), LANES);
        for (int i = 0; i < LANES; i++) begin
          if (i < take) slots[i] = '{cle: 1'b0, ale: 1'b1, ecc: 1'b0, io: wdata[8*i +: 8]};
        end
        count   = CNT_W'(take);
        rem_out = NADDR_W'(int'(rem_in) - take);
      end
      KIND_DATA: begin
        for (int i = 0; i < LANES; i++) begin
          slots[i] = '{cle: 1'b0, ale: 1'b0, ecc: 1'b0, io: wdata[8*i +: 8]};
        end
        slots[LANES-1].ecc = ecc_flag;
        if (cmd2_valid) slots[LANES] = '{cle: 1'b1, ale: 1'b0, ecc: 1'b0, io: opcode};
        count = CNT_W'(data_cycles(LANES, cmd2_valid));
      end
      default: begin
        count = '0;
      end
    endcase
  end

endmodule

// File: rtl/nand_cycle_emitter.sv
module nand_cycle_emitter
  import nand_dec_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  nand_slot_t       slots_in [SLOTS],
  input  logic [CNT_W-1:0] count_in,
  output nand_slot_t       cur,
  output logic             cur_valid,
  output logic             ecc_pulse,
  output logic             idle
);

  nand_slot_t       q [SLOTS];
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] left;

  assign idle = (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur       <= IDLE_SLOT;
      cur_valid <= 1'b0;
      ecc_pulse <= 1'b0;
      pos       <= '0;
      left      <= '0;
    end else begin
      ecc_pulse <= cur_valid & cur.ecc;
      if (load) begin
        q         <= slots_in;
        cur       <= slots_in[0];
        cur_valid <= 1'b1;
        pos       <= CNT_W'(1);
        left      <= count_in - CNT_W'(1);
      end else if (left != '0) begin
        cur       <= q[pos];
        cur_valid <= 1'b1;
        pos       <= pos + CNT_W'(1);
        left      <= left - CNT_W'(1);
      end else begin
        cur       <= IDLE_SLOT;
        cur_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/nand_phase_decoder.sv
module nand_phase_decoder
  import nand_dec_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int CMD_BIT   = 21,
  parameter int DATA_BIT  = 20,
  parameter int NADDR_LSB = 8,
  parameter int NADDR_W   = 3,
  parameter int ECC_BIT   = 12,
  parameter int C2V_BIT   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we,
  output logic [7:0]        nand_io,
  output logic              ecc_last
);

  localparam int LANES = DATA_W / 8;
  localparam int SLOTS = LANES + 1;
  localparam int CNT_W = $clog2(SLOTS + 1);

  // named internal events, observed by the checker
  wr_kind_e           kind;
  logic               accept;
  logic               waiting;
  logic               load;

  logic [7:0]         opcode;
  logic [NADDR_W-1:0] naddr;
  logic               ecc_flag;
  logic               cmd2_valid;
  logic [NADDR_W-1:0] wait_rem;
  logic [NADDR_W-1:0] rem_next;
  nand_slot_t         slots [SLOTS];
  logic [CNT_W-1:0]   count;
  nand_slot_t         cur;
  logic               cur_valid;
  logic               ecc_pulse;
  logic               idle;

  assign waiting  = (wait_rem != '0);
  assign wr_ready = idle;
  assign accept   = wr_valid & wr_ready;
  assign load     = accept && (count != '0);

  nand_offset_decode #(
    .ADDR_W(ADDR_W), .CMD_BIT(CMD_BIT), .DATA_BIT(DATA_BIT), .OPC_LSB(0),
    .NADDR_LSB(NADDR_LSB), .NADDR_W(NADDR_W), .ECC_BIT(ECC_BIT), .C2V_BIT(C2V_BIT)
  ) u_dec (
    .addr(wr_addr), .waiting(waiting), .kind(kind), .opcode(opcode),
    .naddr(naddr), .ecc_flag(ecc_flag), .cmd2_valid(cmd2_valid)
  );

  nand_slot_builder #(.DATA_W(DATA_W), .NADDR_W(NADDR_W)) u_build (
    .kind(kind), .opcode(opcode), .naddr(naddr), .rem_in(wait_rem),
    .wdata(wr_data), .ecc_flag(ecc_flag), .cmd2_valid(cmd2_valid),
    .slots(slots), .count(count), .rem_out(rem_next)
  );

  nand_cycle_emitter #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .load(load), .slots_in(slots), .count_in(count),
    .cur(cur), .cur_valid(cur_valid), .ecc_pulse(ecc_pulse), .idle(idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_rem <= '0;
    end else if (accept && (kind == KIND_CMD_FIRST || kind == KIND_CMD_REST)) begin
      wait_rem <= rem_next;
    end
  end

  assign nand_we  = cur_valid;
  assign nand_cle = cur_valid & cur.cle;
  assign nand_ale = cur_valid & cur.ale;
  assign nand_io  = cur.io;
  assign ecc_last = ecc_pulse;

endmodule

// File: rtl/nand_phase_decoder_chk.sv
module nand_phase_decoder_chk
  import nand_dec_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     wr_ready,
  input logic     accept,
  input wr_kind_e kind,
  input logic     nand_cle,
  input logic     nand_ale,
  input logic     nand_we,
  input logic     ecc_last
);

  assert_latch_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  assert_latch_in_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we |-> (!nand_cle && !nand_ale));

  assert_no_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> nand_we);

  assert_ignored_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == KIND_NONE) |=> !nand_we);

  assert_opcode_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == KIND_CMD_FIRST) |=> (nand_we && nand_cle));

  assert_rest_no_opcode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == KIND_CMD_REST) |=> (nand_we && nand_ale && !nand_cle));

  assert_data_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == KIND_DATA) |=> (nand_we && !nand_cle && !nand_ale));

  assert_ecc_after_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_last |-> ($past(nand_we) && !$past(nand_cle) && !$past(nand_ale)));

  assert_ecc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_last |=> !ecc_last);

endmodule

bind nand_phase_decoder nand_phase_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .accept(accept), .kind(kind),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we(nand_we), .ecc_last(ecc_last)
);

// File: tb/sim_nand_phase_decoder.sv
`timescale 1ns/1ps
module sim_nand_phase_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [23:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        nand_cle, nand_ale, nand_we, ecc_last;
  logic [7:0]  nand_io;

  always #4 clk = ~clk;

  nand_phase_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we(nand_we), .nand_io(nand_io), .ecc_last(ecc_last)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  // recorded stream: kind 0 data, 1 command, 2 address
  int log_k [64];
  int log_b [64];
  int log_c [64];
  int log_n = 0;
  int ecc_c [8];
  int ecc_n = 0;
  int exp_k [64];
  int exp_b [64];
  int exp_n = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (nand_we && log_n < 64) begin
        log_k[log_n] = nand_cle ? 1 : (nand_ale ? 2 : 0);
        log_b[log_n] = int'(nand_io);
        log_c[log_n] = cyc;
        log_n++;
      end
      if (ecc_last && ecc_n < 8) begin
        ecc_c[ecc_n] = cyc;
        ecc_n++;
      end
    end
  end

  function automatic logic [23:0] cmd_off(int n, logic [7:0] op);
    return 24'(1 << 21) | 24'(n << 8) | {16'h0, op};
  endfunction

  function automatic logic [23:0] data_off(bit ecc, bit c2v, logic [7:0] op);
    return 24'(1 << 20) | (ecc ? 24'(1 << 12) : 24'h0) | (c2v ? 24'(1 << 13) : 24'h0) | {16'h0, op};
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clear_logs();
    log_n = 0; ecc_n = 0; exp_n = 0;
  endtask

  task automatic push(int k, int b);
    exp_k[exp_n] = k; exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic wr(logic [23:0] a, logic [31:0] d, output int acc, output int busy);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    acc = cyc + 1;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    busy = 0;
    while (!wr_ready) begin busy++; @(negedge clk); end
  endtask

  task automatic check_stream(int acc, string req);
    chk(log_n == exp_n, {req, " cycle count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_k[i] == exp_k[i], {req, " latch kind"}, log_k[i], exp_k[i]);
      chk(log_b[i] == exp_b[i], {req, " byte"}, log_b[i], exp_b[i]);
      chk(log_c[i] == acc + i, "R8 cycle timing", log_c[i], acc + i);
    end
  endtask

  task automatic t_reset();
    chk(wr_ready == 1'b1, "R9 ready", int'(wr_ready), 1);
    chk(nand_we == 1'b0, "R9 we", int'(nand_we), 0);
    chk(nand_cle == 1'b0 && nand_ale == 1'b0, "R9 latches", int'(nand_cle) + int'(nand_ale), 0);
    chk(ecc_last == 1'b0, "R9 ecc", int'(ecc_last), 0);
  endtask

  task automatic t_cmd_short();
    int acc, busy;
    clear_logs();
    wr(cmd_off(3, 8'h80), 32'h44332211, acc, busy);
    settle();
    push(1, 8'h80); push(2, 8'h11); push(2, 8'h22); push(2, 8'h33);
    check_stream(acc, "R2 R3 three address");
    chk(busy == 3, "R8 ready low", busy, 3);
  endtask

  task automatic t_cmd_zero();
    int acc, busy;
    clear_logs();
    wr(cmd_off(0, 8'hFF), 32'hDEADBEEF, acc, busy);
    settle();
    push(1, 8'hFF);
    check_stream(acc, "R3 zero address");
    chk(busy == 0, "R8 ready low", busy, 0);
  endtask

  task automatic t_cmd_long();
    int acc, busy;
    clear_logs();
    wr(cmd_off(6, 8'h00), 32'hA3A2A1A0, acc, busy);
    settle();
    push(1, 8'h00); push(2, 8'hA0); push(2, 8'hA1); push(2, 8'hA2); push(2, 8'hA3);
    check_stream(acc, "R4 first part");
    clear_logs();
    wr(data_off(1'b1, 1'b1, 8'h10), 32'h55555555, acc, busy);
    settle();
    chk(log_n == 0, "R4 data ignored while waiting", log_n, 0);
    chk(ecc_n == 0, "R4 no ecc while waiting", ecc_n, 0);
    clear_logs();
    wr(cmd_off(6, 8'h00), 32'h0000B5B4, acc, busy);
    settle();
    push(2, 8'hB4); push(2, 8'hB5);
    check_stream(acc, "R4 remainder");
    clear_logs();
    wr(cmd_off(0, 8'h70), 32'h0, acc, busy);
    settle();
    push(1, 8'h70);
    check_stream(acc, "R4 wait cleared");
  endtask

  task automatic t_data_plain();
    int acc, busy;
    clear_logs();
    wr(data_off(1'b0, 1'b0, 8'h10), 32'hDDCCBBAA, acc, busy);
    settle();
    push(0, 8'hAA); push(0, 8'hBB); push(0, 8'hCC); push(0, 8'hDD);
    check_stream(acc, "R5 data word");
    chk(ecc_n == 0, "R6 no ecc without flag", ecc_n, 0);
  endtask

  task automatic t_data_ecc();
    int acc, busy;
    clear_logs();
    wr(data_off(1'b1, 1'b0, 8'h00), 32'h04030201, acc, busy);
    settle();
    push(0, 1); push(0, 2); push(0, 3); push(0, 4);
    check_stream(acc, "R5 R6 flagged word");
    chk(ecc_n == 1, "R6 ecc pulse count", ecc_n, 1);
    if (ecc_n > 0) chk(ecc_c[0] == acc + 4, "R6 ecc timing", ecc_c[0], acc + 4);
  endtask

  task automatic t_data_cmd2();
    int acc, busy;
    clear_logs();
    wr(data_off(1'b1, 1'b1, 8'h10), 32'h9A8B7C6D, acc, busy);
    settle();
    push(0, 8'h6D); push(0, 8'h7C); push(0, 8'h8B); push(0, 8'h9A); push(1, 8'h10);
    check_stream(acc, "R7 trailing command");
    chk(busy == 4, "R8 ready low", busy, 4);
    chk(ecc_n == 1, "R6 ecc pulse count", ecc_n, 1);
    if (ecc_n > 0) chk(ecc_c[0] == acc + 4, "R6 ecc with trailing command", ecc_c[0], acc + 4);
  endtask

  task automatic t_invalid();
    int acc, busy;
    clear_logs();
    wr(24'(1 << 21) | 24'(1 << 20) | 24'h000301, 32'h11111111, acc, busy);
    settle();
    chk(log_n == 0, "R1 both bits ignored", log_n, 0);
    chk(busy == 0, "R1 ready stays high", busy, 0);
    clear_logs();
    wr(24'h003322, 32'h22222222, acc, busy);
    settle();
    chk(log_n == 0, "R1 neither bit ignored", log_n, 0);
    clear_logs();
    wr(cmd_off(1, 8'h90), 32'h00000000, acc, busy);
    settle();
    push(1, 8'h90); push(2, 0);
    check_stream(acc, "R1 command after ignored writes");
  endtask

  task automatic t_back_to_back();
    int acc1, acc2;
    clear_logs();
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = data_off(1'b0, 1'b0, 8'h0); wr_data = 32'h03020100;
    while (!wr_ready) @(negedge clk);
    acc1 = cyc + 1;
    @(posedge clk);
    @(negedge clk);
    wr_data = 32'h07060504;
    while (!wr_ready) @(negedge clk);
    acc2 = cyc + 1;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    settle();
    chk(acc2 == acc1 + 4, "R8 second acceptance", acc2, acc1 + 4);
    for (int i = 0; i < 8; i++) push(0, i);
    check_stream(acc1, "R8 back to back");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd_short();
    t_cmd_zero();
    t_cmd_long();
    t_data_plain();
    t_data_ecc();
    t_data_cmd2();
    t_invalid();
    t_back_to_back();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule